// File: doc/BRIEF.md
# Systolic Longest-Prefix Match Engine

This block is the search core of a sliding-window dictionary compressor. It is given the M symbols waiting to be coded (the look-ahead) and is then fed the search window one symbol per accepted clock. It reports the window position and length of the longest run of window symbols that equals a prefix of the look-ahead. The work is spread over a chain of M identical compare cells and one tracker cell at the end. Every cell compares its own look-ahead symbol with the symbol now on the search bus. A cell extends a run only when its upstream neighbour held a full prefix run on the previous accepted symbol. Candidate results then ripple down the chain to the tracker, which keeps the best one.

A step begins with a load pulse that captures the look-ahead and clears the result. The window then streams in. The clock carrying the final window symbol is flagged. Exactly M clocks after that symbol is accepted, a one-clock done strobe appears, and the pointer and length are valid from then on. Window storage, the step sequencing and the codeword packing sit around this block.

Top module: `lzm_match_top`

## Requirements
- R1: After reset, `done` is 0 and `matchLen` and `matchPtr` are 0.
- R2: A clock with `loadEn` high captures the look-ahead from `codeSyms` and starts a new step. Symbol j (j = 0 is the first symbol to be coded) sits at bits [j*SYM_W +: SYM_W]. After that edge `matchLen` and `matchPtr` are 0 and `done` is 0, whatever the previous step found. A search symbol offered in the same clock is ignored.
- R3: Window positions count accepted search symbols from 0 after the load. `matchPtr` is the position of the first window symbol of the reported run.
- R4: `matchLen` is the largest L for which the L window symbols starting at `matchPtr` equal look-ahead symbols 0..L-1. A run cannot extend past the last window symbol. Within a step the reported length never decreases.
- R5: The length saturates at CODE_LEN: a window holding the complete look-ahead reports CODE_LEN.
- R6: When several positions give the same longest length, the smallest position is reported.
- R7: When no window symbol equals look-ahead symbol 0, `matchLen` and `matchPtr` are both 0.
- R8: `done` is high for exactly one clock, CODE_LEN clocks after the edge that accepts the symbol flagged by `srchLast`. The result is final from that clock and stays unchanged until the next load.
- R9: Clocks with `srchValid` low are not window symbols. They neither break nor extend a run and do not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Capture look-ahead and start a step |
| codeSyms | input | CODE_LEN*SYM_W | Look-ahead symbols, symbol j at bits j*SYM_W |
| srchValid | input | 1 | A window symbol is on `srchSym` |
| srchSym | input | SYM_W | Window symbol |
| srchLast | input | 1 | This window symbol is the final one of the step |
| done | output | 1 | One-clock strobe: result is final |
| matchPtr | output | $clog2(WIN_DEPTH) | Window position where the best run starts |
| matchLen | output | $clog2(CODE_LEN+1) | Length of the best run |

## Verification
On every cycle the assertions check that the done strobe lasts one clock and comes exactly CODE_LEN clocks after the flagged final symbol. They also check that a load clears the result, that the length never exceeds CODE_LEN or shrinks within a step, that a zero length carries a zero pointer, and that the result holds after done. Only the bench's scenarios can show that the reported pointer and length are the true longest match. That covers runs cut off at the window end, ties between positions, a hit at position 0 and streams broken by idle clocks, each compared against a software search over the same window.

// File: rtl/lzm_pkg.sv
package lzm_pkg;
  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic clearStep;  // capture look-ahead, clear runs and result
    logic shiftIn;    // a window symbol is accepted this clock
  } lzmCtrl_t;
endpackage

// File: rtl/lzm_cell.sv
module lzm_cell #(
  parameter int SYM_W = 8,
  parameter int PTR_W = 9,
  parameter int LEN_W = 4,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearStep,
  input  logic             shiftIn,
  input  logic [SYM_W-1:0] codeSym,
  input  logic [SYM_W-1:0] srchSym,
  input  logic             prevHit,
  input  logic [PTR_W-1:0] prevStart,
  input  logic [LEN_W-1:0] prevCandLen,
  input  logic [PTR_W-1:0] prevCandPtr,
  output logic             hit,
  output logic [PTR_W-1:0] startPtr,
  output logic [LEN_W-1:0] candLen,
  output logic [PTR_W-1:0] candPtr
);
  localparam logic [LEN_W-1:0] RUN_LEN = LEN_W'(IDX + 1);

  logic [SYM_W-1:0] codeReg;
  logic             symEq;
  logic             newHit;

  assign symEq  = (codeReg == srchSym);
  // Run continues only if the upstream cell held a full prefix run.
  assign newHit = shiftIn & symEq & prevHit & ~clearStep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeReg  <= '0;
      hit      <= 1'b0;
      startPtr <= '0;
      candLen  <= '0;
      candPtr  <= '0;
    end else if (clearStep) begin
      codeReg  <= codeSym;
      hit      <= 1'b0;
      startPtr <= '0;
      candLen  <= '0;
      candPtr  <= '0;
    end else begin
      if (shiftIn) begin
        hit      <= newHit;
        startPtr <= prevStart;
      end
      // A fresh hit here is longer than anything arriving from upstream.
      candLen <= newHit ? RUN_LEN   : prevCandLen;
      candPtr <= newHit ? prevStart : prevCandPtr;
    end
  end
endmodule

// File: rtl/lzm_tracker.sv
module lzm_tracker #(
  parameter int PTR_W = 9,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearStep,
  input  logic [LEN_W-1:0] candLen,
  input  logic [PTR_W-1:0] candPtr,
  output logic [LEN_W-1:0] bestLen,
  output logic [PTR_W-1:0] bestPtr
);
  logic takeCand;

  // Strictly greater: equal lengths arrive in position order, first kept.
  assign takeCand = (candLen > bestLen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bestLen <= '0;
      bestPtr <= '0;
    end else if (clearStep) begin
      bestLen <= '0;
      bestPtr <= '0;
    end else if (takeCand) begin
      bestLen <= candLen;
      bestPtr <= candPtr;
    end
  end
endmodule

// File: rtl/lzm_datapath.sv
module lzm_datapath
  import lzm_pkg::*;
#(
  parameter int SYM_W    = 8,
  parameter int CODE_LEN = 15,
  parameter int PTR_W    = 9,
  parameter int LEN_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  lzmCtrl_t                  ctrl,
  input  logic [CODE_LEN*SYM_W-1:0] codeSyms,
  input  logic [SYM_W-1:0]          srchSym,
  input  logic [PTR_W-1:0]          curPos,
  output logic [LEN_W-1:0]          bestLen,
  output logic [PTR_W-1:0]          bestPtr
);
  logic             hitV     [CODE_LEN];
  logic [PTR_W-1:0] startV   [CODE_LEN];
  logic [LEN_W-1:0] candLenV [CODE_LEN];
  logic [PTR_W-1:0] candPtrV [CODE_LEN];

  for (genvar j = 0; j < CODE_LEN; j++) begin : g_cell
    logic             upHit;
    logic [PTR_W-1:0] upStart;
    logic [LEN_W-1:0] upLen;
    logic [PTR_W-1:0] upPtr;

    if (j == 0) begin : g_head
      assign upHit   = 1'b1;
      assign upStart = curPos;
      assign upLen   = '0;
      assign upPtr   = '0;
    end else begin : g_body
      assign upHit   = hitV[j-1];
      assign upStart = startV[j-1];
      assign upLen   = candLenV[j-1];
      assign upPtr   = candPtrV[j-1];
    end

    lzm_cell #(
      .SYM_W(SYM_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .IDX(j)
    ) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .clearStep  (ctrl.clearStep),
      .shiftIn    (ctrl.shiftIn),
      .codeSym    (codeSyms[j*SYM_W +: SYM_W]),
      .srchSym    (srchSym),
      .prevHit    (upHit),
      .prevStart  (upStart),
      .prevCandLen(upLen),
      .prevCandPtr(upPtr),
      .hit        (hitV[j]),
      .startPtr   (startV[j]),
      .candLen    (candLenV[j]),
      .candPtr    (candPtrV[j])
    );
  end

  lzm_tracker #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clearStep(ctrl.clearStep),
    .candLen  (candLenV[CODE_LEN-1]),
    .candPtr  (candPtrV[CODE_LEN-1]),
    .bestLen  (bestLen),
    .bestPtr  (bestPtr)
  );
endmodule

// File: rtl/lzm_ctrl.sv
module lzm_ctrl
  import lzm_pkg::*;
#(
  parameter int CODE_LEN = 15,
  parameter int PTR_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadEn,
  input  logic             srchValid,
  input  logic             srchLast,
  output lzmCtrl_t         ctrl,
  output logic [PTR_W-1:0] curPos,
  output logic             done
);
  localparam int CNT_W = $clog2(CODE_LEN + 1);
  localparam logic [CNT_W-1:0] DRAIN_CLKS = CNT_W'(CODE_LEN);

  logic [CNT_W-1:0] drainCnt;

  assign ctrl.clearStep = loadEn;
  assign ctrl.shiftIn   = srchValid & ~loadEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPos   <= '0;
      drainCnt <= '0;
      done     <= 1'b0;
    end else if (loadEn) begin
      curPos   <= '0;
      drainCnt <= '0;
      done     <= 1'b0;
    end else begin
      if (ctrl.shiftIn) curPos <= curPos + 1'b1;
      if (ctrl.shiftIn && srchLast) drainCnt <= DRAIN_CLKS;
      else if (drainCnt != '0)      drainCnt <= drainCnt - 1'b1;
      done <= (drainCnt == CNT_W'(1));
    end
  end
endmodule

// File: rtl/lzm_match_top.sv
module lzm_match_top
  import lzm_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int WIN_DEPTH = 512,
  parameter int CODE_LEN  = 15,
  localparam int PTR_W    = $clog2(WIN_DEPTH),
  localparam int LEN_W    = $clog2(CODE_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      loadEn,
  input  logic [CODE_LEN*SYM_W-1:0] codeSyms,
  input  logic                      srchValid,
  input  logic [SYM_W-1:0]          srchSym,
  input  logic                      srchLast,
  output logic                      done,
  output logic [PTR_W-1:0]          matchPtr,
  output logic [LEN_W-1:0]          matchLen
);
  lzmCtrl_t         ctrl;
  logic [PTR_W-1:0] curPos;

  lzm_ctrl #(.CODE_LEN(CODE_LEN), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadEn   (loadEn),
    .srchValid(srchValid),
    .srchLast (srchLast),
    .ctrl     (ctrl),
    .curPos   (curPos),
    .done     (done)
  );

  lzm_datapath #(
    .SYM_W(SYM_W), .CODE_LEN(CODE_LEN), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .codeSyms(codeSyms),
    .srchSym (srchSym),
    .curPos  (curPos),
    .bestLen (matchLen),
    .bestPtr (matchPtr)
  );
endmodule

// File: rtl/lzm_match_checker.sv
module lzm_match_checker #(
  parameter int CODE_LEN = 15,
  parameter int PTR_W    = 9,
  parameter int LEN_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loadEn,
  input logic             srchValid,
  input logic             srchLast,
  input logic             done,
  input logic [PTR_W-1:0] matchPtr,
  input logic [LEN_W-1:0] matchLen
);
  localparam int CW = $clog2(CODE_LEN + 1);
  logic [CW-1:0] lagCnt;

  // Independent count of clocks since the flagged final symbol.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lagCnt <= '0;
    else if (loadEn)                 lagCnt <= '0;
    else if (srchValid && srchLast)  lagCnt <= CW'(CODE_LEN);
    else if (lagCnt != '0)           lagCnt <= lagCnt - 1'b1;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lagCnt == CW'(1) && !loadEn) |=> done);
  p_hold_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !loadEn) |=> ($stable(matchLen) && $stable(matchPtr)));
  p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |=> (matchLen == '0 && matchPtr == '0 && !done));
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    matchLen <= LEN_W'(CODE_LEN));
  p_len_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !loadEn |=> matchLen >= $past(matchLen));
  p_zero_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (matchLen == '0) |-> (matchPtr == '0));

  always_comb begin
    if (rst_n === 1'b0) begin
      a_reset_state_r1: assert (done == 1'b0 && matchLen == '0 && matchPtr == '0);
    end
  end
endmodule

bind lzm_match_top lzm_match_checker #(
  .CODE_LEN(CODE_LEN), .PTR_W(PTR_W), .LEN_W(LEN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .loadEn   (loadEn),
  .srchValid(srchValid),
  .srchLast (srchLast),
  .done     (done),
  .matchPtr (matchPtr),
  .matchLen (matchLen)
);

// File: tb/lzm_match_top_bench.sv
module lzm_match_top_bench;
  localparam int W = 8;
  localparam int N = 512;
  localparam int M = 15;
  localparam int PW = $clog2(N);
  localparam int LW = $clog2(M + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0;
  logic [M*W-1:0] codeSyms = '0;
  logic srchValid = 1'b0;
  logic [W-1:0] srchSym = '0;
  logic srchLast = 1'b0;
  logic done;
  logic [PW-1:0] matchPtr;
  logic [LW-1:0] matchLen;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] win [N];
  logic [W-1:0] code [M];

  always #5 clk = ~clk;

  lzm_match_top #(.SYM_W(W), .WIN_DEPTH(N), .CODE_LEN(M)) u_lzm_match_top (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .codeSyms(codeSyms),
    .srchValid(srchValid), .srchSym(srchSym), .srchLast(srchLast),
    .done(done), .matchPtr(matchPtr), .matchLen(matchLen)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Software search: longest prefix run, earliest position on ties.
  function automatic void refMatch(input int k, output int bestL, output int bestP);
    bestL = 0; bestP = 0;
    for (int p = 0; p < k; p++) begin
      int l = 0;
      while (l < M && p + l < k && win[p+l] == code[l]) l++;
      if (l > bestL) begin bestL = l; bestP = p; end
    end
  endfunction

  task automatic runStep(input int k, input int gapPct, input string req);
    int expL, expP, doneHits;
    refMatch(k, expL, expP);
    @(negedge clk);
    loadEn = 1'b1;
    for (int j = 0; j < M; j++) codeSyms[j*W +: W] = code[j];
    srchValid = 1'b1; srchSym = 8'h5A;  // offered during load: ignored
    @(negedge clk);
    loadEn = 1'b0; srchValid = 1'b0;
    check("R2", "len after load", int'(matchLen), 0);
    check("R2", "ptr after load", int'(matchPtr), 0);
    for (int i = 0; i < k; i++) begin
      while (($urandom % 100) < gapPct) begin
        srchValid = 1'b0; srchSym = $urandom; srchLast = 1'b0;
        @(negedge clk);
      end
      srchValid = 1'b1; srchSym = win[i]; srchLast = (i == k - 1);
      @(negedge clk);
    end
    srchValid = 1'b0; srchLast = 1'b0;
    doneHits = 0;
    for (int lat = 1; lat <= M + 3; lat++) begin
      @(negedge clk);
      if (done) doneHits++;
      if (lat == M) begin
        check("R8", "done at drain end", int'(done), 1);
        check(req, "length", int'(matchLen), expL);
        check(req, "pointer", int'(matchPtr), expP);
      end
    end
    check("R8", "done pulse count", doneHits, 1);
    check("R8", "length held", int'(matchLen), expL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset len", int'(matchLen), 0);
    check("R1", "reset ptr", int'(matchPtr), 0);
    rst_n = 1'b1;

    // R5: full look-ahead planted at 37 saturates at M.
    for (int i = 0; i < 100; i++) win[i] = $urandom % 4;
    for (int j = 0; j < M; j++) code[j] = $urandom % 4;
    for (int j = 0; j < M; j++) win[37+j] = code[j];
    runStep(100, 0, "R5");

    // R7: no symbol equals look-ahead symbol 0 (also follows a long result: R2).
    for (int j = 0; j < M; j++) code[j] = 8'hFF;
    runStep(80, 0, "R7");

    // R6: two equal runs of length 2 at 10 and 30.
    for (int i = 0; i < 60; i++) win[i] = 8'h00;
    for (int j = 0; j < M; j++) code[j] = 8'(5 + j);
    win[10] = 5; win[11] = 6; win[30] = 5; win[31] = 6;
    runStep(60, 0, "R6");

    // R4: run at window end is cut to 3 symbols.
    for (int i = 0; i < 40; i++) win[i] = 8'h33;
    for (int j = 0; j < M; j++) code[j] = 8'(8'h40 + j);
    win[5] = code[0]; win[6] = code[1];
    win[37] = code[0]; win[38] = code[1]; win[39] = code[2];
    runStep(40, 0, "R4");

    // R3: run at position 0.
    for (int i = 0; i < 30; i++) win[i] = 8'h00;
    for (int j = 0; j < M; j++) code[j] = 8'(8'h80 + j);
    for (int j = 0; j < 6; j++) win[j] = code[j];
    runStep(30, 0, "R3");

    // R9: same as R5 case with idle clocks between symbols.
    for (int i = 0; i < 120; i++) win[i] = $urandom % 4;
    for (int j = 0; j < M; j++) code[j] = $urandom % 4;
    for (int j = 0; j < 9; j++) win[70+j] = code[j];
    runStep(120, 40, "R9");

    // R4: random windows over a small alphabet.
    for (int s = 0; s < 30; s++) begin
      int k = 16 + ($urandom % 300);
      for (int i = 0; i < k; i++) win[i] = $urandom % 3;
      for (int j = 0; j < M; j++) code[j] = $urandom % 3;
      runStep(k, (s % 2) ? 30 : 0, "R4");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule